// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control sequencer for a multicycle processor datapath that shares one memory and one ALU. Every instruction runs over several clock cycles. Each cycle the sequencer sets the datapath's multiplexer selects, its write enables and an ALU operation code. The datapath's registers, memory and ALU sit outside this block. The sequencer sees only the 6-bit opcode and the 6-bit funct field of the instruction register. Because the instruction register holds its value for the whole instruction, both fields stay stable from the decode cycle onward.

This is a Moore machine. All outputs depend only on the current state. The one exception is the ALU code in the R-type execute state, which is decoded from the stable funct field. Every instruction starts with a fetch cycle and a decode cycle. After that, each instruction class follows its own short path of states and then returns to fetch. Branch-equal and branch-not-equal have separate completion states, so the branch polarity is a state output. An opcode or funct code the sequencer does not recognise sends it to a halt state. It stays there with every write enable low until reset.

Top module: `mc_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the outputs are the fetch set: mem_rd=1, ir_wr=1, pc_wr=1, addr_sel=0, alu_a_sel=0, alu_b_sel=1 (constant four), alu_op=2 (add), pc_src=0 (ALU result). Every other output is 0.
- R2: Fetch is always followed by decode. Decode drives alu_a_sel=0, alu_b_sel=3 (shifted sign-extended offset) and alu_op=2, and asserts no write enable.
- R3: For a load (opcode 0x23), three states follow decode in order:
  - an address state with alu_a_sel=1, alu_b_sel=2 (sign-extended offset) and alu_op=2;
  - a read state with mem_rd=1 and addr_sel=1;
  - a write-back state with reg_wr=1, wb_sel_mem=1 and dst_sel_rd=0.
- R4: For a store (opcode 0x2B), decode is followed by the same address state and then a single state with mem_wr=1 and addr_sel=1.
- R5: For an R-type instruction (opcode 0x00), the execute state drives alu_a_sel=1 and alu_b_sel=0. Its alu_op is decoded from funct as follows:
  - 0x20 gives 2 (add), 0x22 gives 3 (sub) and 0x2A gives 4 (slt);
  - 0x24 gives 0 (and), 0x25 gives 1 (or) and 0x27 gives 5 (nor).
- R6: The R-type execute state is followed by a completion state with reg_wr=1, dst_sel_rd=1 and wb_sel_mem=0.
- R7: Branch-equal (opcode 0x04) and branch-not-equal (opcode 0x05) each finish in one state with alu_a_sel=1, alu_b_sel=0, alu_op=3, pc_src=1 and pc_wr_cond=1. In that state br_on_ne is 0 for opcode 0x04 and 1 for opcode 0x05.
- R8: Jump (opcode 0x02) finishes in one state with pc_src=2 and pc_wr=1.
- R9: The last state of every instruction class is followed by fetch.
- R10: An opcode not named in R3 to R8, or an R-type funct not listed in R5, moves the sequencer from decode to a halt state. In that state halted=1 and all write enables are 0. The state is held whatever opcode and funct do, until reset.
- R11: mem_rd and mem_wr are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Funct field of the instruction register |
| addr_sel | output | 1 | Memory address: 0 from PC, 1 from ALU output register |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| ir_wr | output | 1 | Instruction register load |
| dst_sel_rd | output | 1 | Destination register: 0 rt, 1 rd |
| wb_sel_mem | output | 1 | Write-back data: 0 ALU output register, 1 memory data register |
| reg_wr | output | 1 | Register file write enable |
| alu_a_sel | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU operand B: 0 register B, 1 four, 2 offset, 3 offset shifted by two |
| alu_op | output | 3 | ALU operation: 0 and, 1 or, 2 add, 3 sub, 4 slt, 5 nor |
| pc_src | output | 2 | Next PC: 0 ALU result, 1 ALU output register, 2 jump target |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by the ALU zero flag |
| br_on_ne | output | 1 | Branch polarity: 1 takes the branch when not equal |
| halted | output | 1 | Sequencer is in the halt state |

## Verification
The bound assertions check the following on every cycle:
- memory read and write are never both asserted;
- an instruction load is always followed by the decode output set;
- a data-memory read is always followed by a register write-back from memory;
- every instruction-ending write leads back to an instruction load;
- the halt state is sticky and never asserts a write enable.

Some properties can only be shown by the bench's sweeps over every opcode and every funct value:
- the exact state order of each instruction class;
- the funct-to-ALU-code table;
- branch polarity;
- that opcode and funct changes are ignored while halted.

// File: rtl/mc_sequencer.sv
module mc_sequencer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output logic       addr_sel,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       ir_wr,
  output logic       dst_sel_rd,
  output logic       wb_sel_mem,
  output logic       reg_wr,
  output logic       alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic [2:0] alu_op,
  output logic [1:0] pc_src,
  output logic       pc_wr,
  output logic       pc_wr_cond,
  output logic       br_on_ne,
  output logic       halted
);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  localparam logic [2:0] ALU_AND = 3'd0;
  localparam logic [2:0] ALU_OR  = 3'd1;
  localparam logic [2:0] ALU_ADD = 3'd2;
  localparam logic [2:0] ALU_SUB = 3'd3;
  localparam logic [2:0] ALU_SLT = 3'd4;
  localparam logic [2:0] ALU_NOR = 3'd5;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_LD_RD, ST_LD_WB, ST_ST_WR,
    ST_R_EXEC, ST_R_DONE, ST_BR_EQ, ST_BR_NE, ST_JUMP, ST_HALT
  } state_t;

  state_t state, state_nx;
  logic   funct_ok;
  logic [2:0] funct_op;

  always_comb begin
    funct_ok = 1'b1;
    funct_op = ALU_ADD;
    case (funct)
      6'h20: funct_op = ALU_ADD;
      6'h22: funct_op = ALU_SUB;
      6'h24: funct_op = ALU_AND;
      6'h25: funct_op = ALU_OR;
      6'h27: funct_op = ALU_NOR;
      6'h2A: funct_op = ALU_SLT;
      default: funct_ok = 1'b0;
    endcase
  end

  always_comb begin
    state_nx = state;
    case (state)
      ST_FETCH:  state_nx = ST_DECODE;
      ST_DECODE:
        case (opcode)
          OP_RTYPE: state_nx = funct_ok ? ST_R_EXEC : ST_HALT;
          OP_LOAD,
          OP_STORE: state_nx = ST_ADDR;
          OP_BEQ:   state_nx = ST_BR_EQ;
          OP_BNE:   state_nx = ST_BR_NE;
          OP_JUMP:  state_nx = ST_JUMP;
          default:  state_nx = ST_HALT;
        endcase
      ST_ADDR:   state_nx = (opcode == OP_LOAD) ? ST_LD_RD : ST_ST_WR;
      ST_LD_RD:  state_nx = ST_LD_WB;
      ST_R_EXEC: state_nx = ST_R_DONE;
      ST_HALT:   state_nx = ST_HALT;
      default:   state_nx = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= ST_FETCH;
    else        state <= state_nx;

  always_comb begin
    addr_sel = 1'b0; mem_rd = 1'b0; mem_wr = 1'b0; ir_wr = 1'b0;
    dst_sel_rd = 1'b0; wb_sel_mem = 1'b0; reg_wr = 1'b0;
    alu_a_sel = 1'b0; alu_b_sel = 2'd0; alu_op = ALU_ADD;
    pc_src = 2'd0; pc_wr = 1'b0; pc_wr_cond = 1'b0; br_on_ne = 1'b0;
    case (state)
      ST_FETCH: begin
        mem_rd = 1'b1; ir_wr = 1'b1; alu_b_sel = 2'd1; pc_wr = 1'b1;
      end
      ST_DECODE: alu_b_sel = 2'd3;
      ST_ADDR: begin
        alu_a_sel = 1'b1; alu_b_sel = 2'd2;
      end
      ST_LD_RD: begin
        mem_rd = 1'b1; addr_sel = 1'b1;
      end
      ST_LD_WB: begin
        reg_wr = 1'b1; wb_sel_mem = 1'b1;
      end
      ST_ST_WR: begin
        mem_wr = 1'b1; addr_sel = 1'b1;
      end
      ST_R_EXEC: begin
        alu_a_sel = 1'b1; alu_op = funct_op;
      end
      ST_R_DONE: begin
        reg_wr = 1'b1; dst_sel_rd = 1'b1;
      end
      ST_BR_EQ, ST_BR_NE: begin
        alu_a_sel = 1'b1; alu_op = ALU_SUB; pc_src = 2'd1;
        pc_wr_cond = 1'b1; br_on_ne = (state == ST_BR_NE);
      end
      ST_JUMP: begin
        pc_src = 2'd2; pc_wr = 1'b1;
      end
      default: ;
    endcase
  end

  assign halted = (state == ST_HALT);

endmodule

// File: rtl/mc_sequencer_chk.sv
module mc_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr_sel,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       ir_wr,
  input logic       wb_sel_mem,
  input logic       reg_wr,
  input logic       alu_a_sel,
  input logic [1:0] alu_b_sel,
  input logic [1:0] pc_src,
  input logic       pc_wr,
  input logic       pc_wr_cond,
  input logic       halted
);

  // R11
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R2
  decode_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |=> (!ir_wr && !pc_wr && !reg_wr && !mem_wr && !alu_a_sel && alu_b_sel == 2'd3));

  // R3
  load_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && addr_sel) |=> (reg_wr && wb_sel_mem));

  // R9
  back_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || mem_wr || pc_wr_cond || (pc_wr && pc_src == 2'd2)) |=> ir_wr);

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !(mem_rd || mem_wr || ir_wr || reg_wr || pc_wr || pc_wr_cond));

endmodule

bind mc_sequencer mc_sequencer_chk u_chk (.*);

// File: tb/mc_sequencer_tb.sv
`timescale 1ns/1ps
module mc_sequencer_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic [5:0] funct = 6'h20;
  logic addr_sel, mem_rd, mem_wr, ir_wr, dst_sel_rd, wb_sel_mem, reg_wr, alu_a_sel;
  logic [1:0] alu_b_sel, pc_src;
  logic [2:0] alu_op;
  logic pc_wr, pc_wr_cond, br_on_ne, halted;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  mc_sequencer u_dut (.*);

  localparam int S_F = 0, S_D = 1, S_AD = 2, S_LR = 3, S_LW = 4, S_SW = 5,
                 S_RE = 6, S_RD = 7, S_BE = 8, S_BN = 9, S_J = 10, S_H = 11;

  wire [18:0] obs = {addr_sel, mem_rd, mem_wr, ir_wr, dst_sel_rd, wb_sel_mem, reg_wr,
                     alu_a_sel, alu_b_sel, alu_op, pc_src, pc_wr, pc_wr_cond, br_on_ne, halted};

  function automatic logic [2:0] fn_op(input logic [5:0] fn);
    case (fn)
      6'h20: return 3'd2;
      6'h22: return 3'd3;
      6'h24: return 3'd0;
      6'h25: return 3'd1;
      6'h27: return 3'd5;
      6'h2A: return 3'd4;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [18:0] expv(input int s, input logic [5:0] fn);
    logic as_, mr, mw, iw, ds, wb, rw, sa, pw, pc, ne, h;
    logic [1:0] sb, ps;
    logic [2:0] op;
    {as_, mr, mw, iw, ds, wb, rw, sa, pw, pc, ne, h} = '0;
    sb = 2'd0; ps = 2'd0; op = 3'd2;
    case (s)
      S_F:  begin mr = 1; iw = 1; pw = 1; sb = 2'd1; end
      S_D:  sb = 2'd3;
      S_AD: begin sa = 1; sb = 2'd2; end
      S_LR: begin mr = 1; as_ = 1; end
      S_LW: begin rw = 1; wb = 1; end
      S_SW: begin mw = 1; as_ = 1; end
      S_RE: begin sa = 1; op = fn_op(fn); end
      S_RD: begin rw = 1; ds = 1; end
      S_BE: begin sa = 1; op = 3'd3; ps = 2'd1; pc = 1; end
      S_BN: begin sa = 1; op = 3'd3; ps = 2'd1; pc = 1; ne = 1; end
      S_J:  begin ps = 2'd2; pw = 1; end
      S_H:  h = 1;
      default: ;
    endcase
    return {as_, mr, mw, iw, ds, wb, rw, sa, sb, op, ps, pw, pc, ne, h};
  endfunction

  task automatic chk(input int s, input string tag);
    logic [18:0] e;
    e = expv(s, funct);
    checks++;
    if (obs !== e) begin
      errors++;
      $display("FAIL %s op=%h fn=%h step=%0d actual=%b expected=%b", tag, opcode, funct, s, obs, e);
    end
  endtask

  task automatic adv;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(S_F, "R1 during reset");
    rst_n = 1'b1;
    chk(S_F, "R1 after reset");
  endtask

  task automatic run(input logic [5:0] op, input logic [5:0] fn);
    opcode = op;
    funct = fn;
    chk(S_F, "R9 fetch");
    adv; chk(S_D, "R2 decode");
    adv;
    case (op)
      6'h23: begin chk(S_AD, "R3 addr"); adv; chk(S_LR, "R3 read"); adv; chk(S_LW, "R3 writeback"); adv; end
      6'h2B: begin chk(S_AD, "R4 addr"); adv; chk(S_SW, "R4 write"); adv; end
      6'h04: begin chk(S_BE, "R7 beq"); adv; end
      6'h05: begin chk(S_BN, "R7 bne"); adv; end
      6'h02: begin chk(S_J, "R8 jump"); adv; end
      6'h00: begin
        if (fn_op(fn) != 3'd7) begin
          chk(S_RE, "R5 exec"); adv; chk(S_RD, "R6 done"); adv;
        end else begin
          chk(S_H, "R10 bad funct");
          for (int k = 0; k < 3; k++) begin
            opcode = 6'h23; funct = 6'h20; adv; chk(S_H, "R10 held");
          end
          do_reset;
        end
      end
      default: begin
        chk(S_H, "R10 bad opcode");
        for (int k = 0; k < 3; k++) begin
          opcode = 6'h02 ^ 6'(k); funct = 6'h2A; adv; chk(S_H, "R10 held");
        end
        do_reset;
      end
    endcase
    chk(S_F, "R9 return");
  endtask

  initial begin
    @(negedge clk);
    chk(S_F, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    chk(S_F, "R1 first cycle");
    run(6'h23, 6'h00);
    run(6'h2B, 6'h00);
    run(6'h04, 6'h00);
    run(6'h05, 6'h00);
    run(6'h02, 6'h00);
    for (int f = 0; f < 64; f++) run(6'h00, 6'(f));
    for (int o = 0; o < 64; o++) run(6'(o), 6'h20);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule